// File: doc/BRIEF.md
# Memory Block Copy and Search Sequencer

This block runs repeated byte operations over a memory through a single synchronous port. A command supplies a starting source pointer, a destination pointer, a 16-bit iteration counter and a key byte. It also picks one of two operations, a direction, and whether to run once or repeat. In copy operation every iteration reads the byte at the source pointer and writes it to the destination pointer. In search operation every iteration reads the byte at the source pointer and compares it with the key. A search never writes to memory.

After each iteration the pointers move by one in the chosen direction and the counter drops by one. A repeated copy runs until the counter reaches zero. A repeated search stops at whichever comes first: the counter reaching zero, or a byte that equals the key. When the command finishes, the block returns the final pointers and counter. It also returns two flags. The first shows whether count remains. The second shows whether the last byte compared equalled the key.

The memory port holds a request until the memory accepts it. This lets the block work with memories that are slow or shared.

Top module: `memblk_seq`

## Requirements
- R1: In copy operation (cmd_search=0) each iteration reads the byte at the source pointer and then writes that same byte to the destination pointer.
- R2: After each iteration the source pointer and the destination pointer (copy only) both move by one: up when cmd_down=0, down when cmd_down=1, wrapping modulo 65536. The counter decreases by one each iteration.
- R3: With cmd_repeat=1 the operation keeps iterating until the counter becomes zero. A starting count of 0 gives 65536 iterations.
- R4: With cmd_repeat=0 exactly one iteration is performed. In both operations, flag_pv at completion is 1 exactly when the final counter is nonzero.
- R5: In search operation (cmd_search=1) the block never asserts mem_we. The destination result equals the loaded destination value.
- R6: A repeated search stops after the first compared byte that equals the key, or when the counter becomes zero, whichever comes first.
- R7: After a search, res_src points one past the last compared byte in the chosen direction. flag_z is 1 exactly when that byte equalled the key. A copy leaves flag_z at 0.
- R8: A search that finds no matching byte over the whole count ends with flag_pv=0 and flag_z=0.
- R9: A command is taken only while busy=0 and done=0. Commands that arrive at any other time are ignored. done is a one-cycle pulse in the cycle after the final memory transfer. With no stalls, a single copy raises done 3 cycles after the command and a single search raises it 2 cycles after the command.
- R10: A memory transfer completes in a cycle where mem_req and mem_ready are both high, and read data is taken in that cycle. While mem_ready is low, mem_req, mem_we, mem_addr and mem_wdata hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_search | input | 1 | 1 = search, 0 = copy |
| cmd_down | input | 1 | 1 = pointers decrement, 0 = increment |
| cmd_repeat | input | 1 | 1 = repeat, 0 = single iteration |
| cmd_key | input | 8 | Key byte for search |
| cmd_src | input | 16 | Starting source pointer |
| cmd_dst | input | 16 | Starting destination pointer |
| cmd_count | input | 16 | Starting counter (0 means 65536) |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 16 | Memory address |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, valid when mem_ready is high |
| mem_ready | input | 1 | Memory accepts the request this cycle |
| res_src | output | 16 | Current/final source pointer |
| res_dst | output | 16 | Current/final destination pointer |
| res_count | output | 16 | Current/final counter |
| flag_pv | output | 1 | Count-remaining flag |
| flag_z | output | 1 | Last compared byte equalled key |

## Verification
The assertions check these rules on every cycle:
- A stalled request holds steady.
- A search never writes.
- Each completed iteration lowers the counter by one and steps the destination in the chosen direction.
- done is a single pulse and never overlaps busy.
- A single-step command ends after one iteration.
- flag_pv agrees with the final counter.
- flag_z stays clear after a copy.

Only the directed scenarios can show the rest:
- The bytes that land in memory.
- The exact stop point of a search that matches going up and going down.
- A match on the last counted byte.
- The no-match result.
- The 65536-iteration run from a zero count.
- Pointer wrap.
- Rejection of a command issued mid-run.

// File: rtl/memblk_pkg.sv
package memblk_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_WRITE = 2'd2,
    ST_DONE  = 2'd3
  } seq_state_t;
endpackage

// File: rtl/memblk_ptr.sv
// One address pointer: loadable, steps by one up or down.
module memblk_ptr #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_en,
  input  logic [W-1:0] load_val,
  input  logic         step_en,
  input  logic         step_down,
  output logic [W-1:0] q
);
  logic [W-1:0] q_next;

  always_comb begin
    q_next = q;
    if (load_en)
      q_next = load_val;
    else if (step_en)
      q_next = step_down ? (q - W'(1)) : (q + W'(1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      q <= '0;
    else if (load_en || step_en)
      q <= q_next;
  end
endmodule

// File: rtl/memblk_cnt.sv
// Iteration counter; flags when the next decrement reaches zero.
module memblk_cnt #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_en,
  input  logic [W-1:0] load_val,
  input  logic         dec_en,
  output logic [W-1:0] q,
  output logic         hits_zero
);
  logic [W-1:0] q_next;
  logic [W-1:0] q_minus;

  assign q_minus   = q - W'(1);
  assign hits_zero = (q_minus == '0);

  always_comb begin
    q_next = q;
    if (load_en)
      q_next = load_val;
    else if (dec_en)
      q_next = q_minus;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      q <= '0;
    else if (load_en || dec_en)
      q <= q_next;
  end
endmodule

// File: rtl/memblk_ctrl.sv
// Sequencer: holds the operation mode and steps through read/write phases.
module memblk_ctrl
  import memblk_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cmd_valid,
  input  logic cmd_search,
  input  logic cmd_down,
  input  logic cmd_repeat,
  input  logic mem_ready,
  input  logic byte_match,
  input  logic cnt_hits_zero,
  output logic accept,
  output logic op_search,
  output logic op_down,
  output logic rd_xfer,
  output logic wr_xfer,
  output logic iter_end,
  output logic in_write,
  output logic busy,
  output logic done
);
  seq_state_t state_q, state_d;
  logic       search_q, down_q, rep_q;
  logic       finish;

  assign accept    = cmd_valid && (state_q == ST_IDLE);
  assign op_search = search_q;
  assign op_down   = down_q;
  assign in_write  = (state_q == ST_WRITE);
  assign busy      = (state_q == ST_READ) || (state_q == ST_WRITE);
  assign done      = (state_q == ST_DONE);
  assign rd_xfer   = (state_q == ST_READ) && mem_ready;
  assign wr_xfer   = (state_q == ST_WRITE) && mem_ready;
  assign iter_end  = (rd_xfer && search_q) || wr_xfer;

  // stop rule: single step, counter exhausted, or a search hit
  always_comb begin
    finish = !rep_q || cnt_hits_zero;
    if (search_q && byte_match)
      finish = 1'b1;
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (accept) state_d = ST_READ;
      ST_READ: begin
        if (rd_xfer) begin
          if (!search_q)
            state_d = ST_WRITE;
          else if (finish)
            state_d = ST_DONE;
        end
      end
      ST_WRITE: begin
        if (wr_xfer)
          state_d = finish ? ST_DONE : ST_READ;
      end
      ST_DONE:  state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      state_q <= ST_IDLE;
    else
      state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      search_q <= 1'b0;
      down_q   <= 1'b0;
      rep_q    <= 1'b0;
    end else if (accept) begin
      search_q <= cmd_search;
      down_q   <= cmd_down;
      rep_q    <= cmd_repeat;
    end
  end
endmodule

// File: rtl/memblk_seq.sv
// Top: block copy / compare-search engine over one synchronous memory port.
module memblk_seq #(
  parameter int AW = 16,
  parameter int DW = 8,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  input  logic          cmd_search,
  input  logic          cmd_down,
  input  logic          cmd_repeat,
  input  logic [DW-1:0] cmd_key,
  input  logic [AW-1:0] cmd_src,
  input  logic [AW-1:0] cmd_dst,
  input  logic [CW-1:0] cmd_count,
  output logic          busy,
  output logic          done,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  input  logic          mem_ready,
  output logic [AW-1:0] res_src,
  output logic [AW-1:0] res_dst,
  output logic [CW-1:0] res_count,
  output logic          flag_pv,
  output logic          flag_z
);
  localparam int NPTR = 2;  // 0 = source, 1 = destination

  logic          accept, op_search, op_down;
  logic          rd_xfer, wr_xfer, iter_end, in_write;
  logic          byte_match, cnt_hits_zero;
  logic [DW-1:0] key_q, data_q, data_d;
  logic          pv_d, z_d;

  logic [AW-1:0] ptr_load [NPTR];
  logic          ptr_step [NPTR];
  logic [AW-1:0] ptr_q    [NPTR];

  assign byte_match = (mem_rdata == key_q);

  memblk_ctrl u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .cmd_valid     (cmd_valid),
    .cmd_search    (cmd_search),
    .cmd_down      (cmd_down),
    .cmd_repeat    (cmd_repeat),
    .mem_ready     (mem_ready),
    .byte_match    (byte_match),
    .cnt_hits_zero (cnt_hits_zero),
    .accept        (accept),
    .op_search     (op_search),
    .op_down       (op_down),
    .rd_xfer       (rd_xfer),
    .wr_xfer       (wr_xfer),
    .iter_end      (iter_end),
    .in_write      (in_write),
    .busy          (busy),
    .done          (done)
  );

  // source steps at every iteration end; destination only on a copy write
  assign ptr_load[0] = cmd_src;
  assign ptr_load[1] = cmd_dst;
  assign ptr_step[0] = iter_end;
  assign ptr_step[1] = wr_xfer;

  for (genvar g = 0; g < NPTR; g++) begin : g_ptr
    memblk_ptr #(.W(AW)) u_ptr (
      .clk       (clk),
      .rst_n     (rst_n),
      .load_en   (accept),
      .load_val  (ptr_load[g]),
      .step_en   (ptr_step[g]),
      .step_down (op_down),
      .q         (ptr_q[g])
    );
  end

  memblk_cnt #(.W(CW)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_en   (accept),
    .load_val  (cmd_count),
    .dec_en    (iter_end),
    .q         (res_count),
    .hits_zero (cnt_hits_zero)
  );

  assign res_src = ptr_q[0];
  assign res_dst = ptr_q[1];

  // memory port
  assign mem_req   = busy;
  assign mem_we    = in_write;
  assign mem_addr  = in_write ? ptr_q[1] : ptr_q[0];
  assign mem_wdata = data_q;

  // key and copy data holding registers
  assign data_d = mem_rdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      key_q <= '0;
    else if (accept)
      key_q <= cmd_key;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      data_q <= '0;
    else if (rd_xfer && !op_search)
      data_q <= data_d;
  end

  // flags, updated at the end of every iteration
  always_comb begin
    pv_d = !cnt_hits_zero;
    z_d  = op_search && byte_match;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_pv <= 1'b0;
      flag_z  <= 1'b0;
    end else if (iter_end) begin
      flag_pv <= pv_d;
      flag_z  <= z_d;
    end
  end
endmodule

// File: rtl/memblk_chk.sv
module memblk_chk #(
  parameter int AW = 16,
  parameter int DW = 8,
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cmd_valid,
  input logic          cmd_search,
  input logic          cmd_down,
  input logic          cmd_repeat,
  input logic          busy,
  input logic          done,
  input logic          mem_req,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic [DW-1:0] mem_wdata,
  input logic          mem_ready,
  input logic [AW-1:0] res_dst,
  input logic [CW-1:0] res_count,
  input logic          flag_pv,
  input logic          flag_z
);
  logic       c_search, c_down, c_rep;
  logic [1:0] c_iters;
  logic       c_take, c_iter;

  assign c_take = cmd_valid && !busy && !done;
  assign c_iter = mem_req && mem_ready && (mem_we || c_search);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c_search <= 1'b0;
      c_down   <= 1'b0;
      c_rep    <= 1'b0;
      c_iters  <= 2'd0;
    end else if (c_take) begin
      c_search <= cmd_search;
      c_down   <= cmd_down;
      c_rep    <= cmd_repeat;
      c_iters  <= 2'd0;
    end else if (c_iter && c_iters != 2'd2) begin
      c_iters  <= c_iters + 2'd1;
    end
  end

  p_hold_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ready |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

  p_no_write_search_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we |-> !c_search);

  p_cnt_dec_r2: assert property (@(posedge clk) disable iff (!rst_n)
    c_iter |=> res_count == $past(res_count) - CW'(1));

  p_dst_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we && mem_ready |=>
      res_dst == (c_down ? $past(res_dst) - AW'(1) : $past(res_dst) + AW'(1)));

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && !mem_req);

  p_single_iter_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> c_rep || c_iters == 2'd1);

  p_pv_count_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> flag_pv == (res_count != '0));

  p_copy_z_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done && !c_search |-> !flag_z);
endmodule

bind memblk_seq memblk_chk #(.AW(AW), .DW(DW), .CW(CW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cmd_valid  (cmd_valid),
  .cmd_search (cmd_search),
  .cmd_down   (cmd_down),
  .cmd_repeat (cmd_repeat),
  .busy       (busy),
  .done       (done),
  .mem_req    (mem_req),
  .mem_we     (mem_we),
  .mem_addr   (mem_addr),
  .mem_wdata  (mem_wdata),
  .mem_ready  (mem_ready),
  .res_dst    (res_dst),
  .res_count  (res_count),
  .flag_pv    (flag_pv),
  .flag_z     (flag_z)
);

// File: tb/sim_memblk_seq.sv
`timescale 1ns/1ps
module sim_memblk_seq;
  logic        clk, rst_n;
  logic        cmd_valid, cmd_search, cmd_down, cmd_repeat;
  logic [7:0]  cmd_key;
  logic [15:0] cmd_src, cmd_dst, cmd_count;
  logic        busy, done, mem_req, mem_we, mem_ready;
  logic [15:0] mem_addr;
  logic [7:0]  mem_wdata, mem_rdata;
  logic [15:0] res_src, res_dst, res_count;
  logic        flag_pv, flag_z;

  int checks = 0;
  int failures = 0;
  int rd_cnt = 0;
  int wr_cnt = 0;
  int cyc_cnt = 0;
  bit stall_en = 1'b0;

  logic [7:0] mem [0:4095];

  memblk_seq u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_search(cmd_search),
    .cmd_down(cmd_down), .cmd_repeat(cmd_repeat), .cmd_key(cmd_key),
    .cmd_src(cmd_src), .cmd_dst(cmd_dst), .cmd_count(cmd_count),
    .busy(busy), .done(done), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .mem_ready(mem_ready), .res_src(res_src), .res_dst(res_dst),
    .res_count(res_count), .flag_pv(flag_pv), .flag_z(flag_z)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  assign mem_rdata = mem[mem_addr[11:0]];

  always @(posedge clk) begin
    cyc_cnt <= cyc_cnt + 1;
    if (rst_n && mem_req && mem_ready) begin
      if (mem_we) begin
        mem[mem_addr[11:0]] <= mem_wdata;
        wr_cnt <= wr_cnt + 1;
      end else begin
        rd_cnt <= rd_cnt + 1;
      end
    end
  end

  always @(negedge clk)
    mem_ready <= !stall_en || (cyc_cnt % 3 != 0);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // drive a command at a negedge; return at the negedge where done is seen
  task automatic run_cmd(input bit srch, input bit dn, input bit rep, input logic [7:0] key,
                         input logic [15:0] s, input logic [15:0] d, input logic [15:0] c,
                         output int cyc);
    @(negedge clk);
    rd_cnt = 0; wr_cnt = 0;
    cmd_valid = 1'b1; cmd_search = srch; cmd_down = dn; cmd_repeat = rep;
    cmd_key = key; cmd_src = s; cmd_dst = d; cmd_count = c;
    @(negedge clk);
    cmd_valid = 1'b0;
    cyc = 1;
    while (!done && cyc < 150000) begin
      @(negedge clk);
      cyc++;
    end
    chk("R9 done seen", {31'd0, done}, 32'd1);
  endtask

  task automatic pulse_end();
    @(negedge clk);
    chk("R9 done one cycle", {31'd0, done}, 32'd0);
  endtask

  task automatic t_reset();
    chk("R9 reset busy", {31'd0, busy}, 32'd0);
    chk("R9 reset done", {31'd0, done}, 32'd0);
    chk("R10 reset req", {31'd0, mem_req}, 32'd0);
  endtask

  task automatic t_single_copy_up();
    int cyc;
    run_cmd(0, 0, 0, 8'h00, 16'h0010, 16'h0200, 16'd5, cyc);
    chk("R1 byte copied", {24'd0, mem[12'h200]}, 32'h10);
    chk("R2 src up", {16'd0, res_src}, 32'h0011);
    chk("R2 dst up", {16'd0, res_dst}, 32'h0201);
    chk("R2 count", {16'd0, res_count}, 32'd4);
    chk("R4 pv set", {31'd0, flag_pv}, 32'd1);
    chk("R7 copy z clear", {31'd0, flag_z}, 32'd0);
    chk("R9 copy latency", cyc, 32'd3);
    chk("R4 one write", wr_cnt, 32'd1);
    pulse_end();
  endtask

  task automatic t_single_copy_last();
    int cyc;
    run_cmd(0, 0, 0, 8'h00, 16'h0020, 16'h0210, 16'd1, cyc);
    chk("R4 count zero", {16'd0, res_count}, 32'd0);
    chk("R4 pv clear", {31'd0, flag_pv}, 32'd0);
    pulse_end();
  endtask

  task automatic t_repeat_copy_up_stall();
    int cyc;
    stall_en = 1'b1;
    run_cmd(0, 0, 1, 8'h00, 16'h0040, 16'h0300, 16'd8, cyc);
    stall_en = 1'b0;
    for (int i = 0; i < 8; i++)
      chk("R1 R10 stalled copy byte", {24'd0, mem[12'h300 + i]}, 32'h40 + i);
    chk("R3 writes", wr_cnt, 32'd8);
    chk("R3 src end", {16'd0, res_src}, 32'h0048);
    chk("R3 dst end", {16'd0, res_dst}, 32'h0308);
    chk("R3 count end", {16'd0, res_count}, 32'd0);
    chk("R4 pv end", {31'd0, flag_pv}, 32'd0);
    pulse_end();
  endtask

  task automatic t_repeat_copy_down();
    int cyc;
    run_cmd(0, 1, 1, 8'h00, 16'h005F, 16'h03FF, 16'd4, cyc);
    for (int i = 0; i < 4; i++)
      chk("R2 down copy byte", {24'd0, mem[12'h3FF - i]}, 32'h5F - i);
    chk("R2 src down", {16'd0, res_src}, 32'h005B);
    chk("R2 dst down", {16'd0, res_dst}, 32'h03FB);
    pulse_end();
  endtask

  task automatic t_search_up_match();
    int cyc;
    run_cmd(1, 0, 1, 8'hC5, 16'h01A0, 16'h0777, 16'd16, cyc);
    chk("R6 compares", rd_cnt, 32'd6);
    chk("R7 src past match", {16'd0, res_src}, 32'h01A6);
    chk("R6 count left", {16'd0, res_count}, 32'd10);
    chk("R4 pv left", {31'd0, flag_pv}, 32'd1);
    chk("R7 z match", {31'd0, flag_z}, 32'd1);
    chk("R5 no writes", wr_cnt, 32'd0);
    chk("R5 dst kept", {16'd0, res_dst}, 32'h0777);
    pulse_end();
  endtask

  task automatic t_search_down_match();
    int cyc;
    run_cmd(1, 1, 1, 8'hC5, 16'h01AA, 16'h0000, 16'd16, cyc);
    chk("R7 src before match", {16'd0, res_src}, 32'h01A4);
    chk("R6 down count", {16'd0, res_count}, 32'd10);
    chk("R7 down z", {31'd0, flag_z}, 32'd1);
    pulse_end();
  endtask

  task automatic t_search_none();
    int cyc;
    run_cmd(1, 0, 1, 8'hC6, 16'h0100, 16'h0000, 16'd20, cyc);
    chk("R8 src end", {16'd0, res_src}, 32'h0114);
    chk("R8 count", {16'd0, res_count}, 32'd0);
    chk("R8 pv clear", {31'd0, flag_pv}, 32'd0);
    chk("R8 z clear", {31'd0, flag_z}, 32'd0);
    pulse_end();
  endtask

  task automatic t_search_single();
    int cyc;
    run_cmd(1, 0, 0, 8'hC6, 16'h0100, 16'h0000, 16'd3, cyc);
    chk("R4 single search src", {16'd0, res_src}, 32'h0101);
    chk("R4 single search count", {16'd0, res_count}, 32'd2);
    chk("R4 single search pv", {31'd0, flag_pv}, 32'd1);
    chk("R9 search latency", cyc, 32'd2);
    pulse_end();
  endtask

  task automatic t_search_last_match();
    int cyc;
    run_cmd(1, 0, 1, 8'hC5, 16'h01A3, 16'h0000, 16'd3, cyc);
    chk("R6 last src", {16'd0, res_src}, 32'h01A6);
    chk("R6 last count", {16'd0, res_count}, 32'd0);
    chk("R6 last pv", {31'd0, flag_pv}, 32'd0);
    chk("R7 last z", {31'd0, flag_z}, 32'd1);
    pulse_end();
  endtask

  task automatic t_ignore_busy();
    int cyc;
    fork
      run_cmd(0, 0, 1, 8'h00, 16'h0080, 16'h0400, 16'd12, cyc);
      begin
        repeat (4) @(negedge clk);
        cmd_valid = 1'b1; cmd_search = 1'b1; cmd_src = 16'h0000;
        cmd_dst = 16'h0123; cmd_count = 16'd1; cmd_repeat = 1'b0;
        @(negedge clk);
        cmd_valid = 1'b0;
      end
    join
    chk("R9 ignored src", {16'd0, res_src}, 32'h008C);
    chk("R9 ignored dst", {16'd0, res_dst}, 32'h040C);
    chk("R9 ignored writes", wr_cnt, 32'd12);
    chk("R9 ignored last byte", {24'd0, mem[12'h40B]}, 32'h0B);
    pulse_end();
  endtask

  task automatic t_wrap_down();
    int cyc;
    run_cmd(0, 1, 0, 8'h00, 16'h0000, 16'h0000, 16'd2, cyc);
    chk("R2 src wrap", {16'd0, res_src}, 32'hFFFF);
    chk("R2 dst wrap", {16'd0, res_dst}, 32'hFFFF);
    pulse_end();
  endtask

  task automatic t_full_count();
    int cyc;
    run_cmd(1, 0, 1, 8'hC6, 16'h0000, 16'h0000, 16'd0, cyc);
    chk("R3 65536 reads", rd_cnt, 32'd65536);
    chk("R3 src wraps home", {16'd0, res_src}, 32'h0000);
    chk("R3 count zero", {16'd0, res_count}, 32'd0);
    chk("R8 full pv", {31'd0, flag_pv}, 32'd0);
    pulse_end();
  endtask

  initial begin
    for (int i = 0; i < 4096; i++) mem[i] = 8'(i & 16'h7F);
    mem[12'h1A5] = 8'hC5;
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_search = 1'b0; cmd_down = 1'b0;
    cmd_repeat = 1'b0; cmd_key = '0; cmd_src = '0; cmd_dst = '0; cmd_count = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_single_copy_up();
    t_single_copy_last();
    t_repeat_copy_up_stall();
    t_repeat_copy_down();
    t_search_up_match();
    t_search_down_match();
    t_search_none();
    t_search_single();
    t_search_last_match();
    t_ignore_busy();
    t_wrap_down();
    t_full_count();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule